// File: doc/BRIEF.md
# DAC Register Access SPI Engine

This block sits on the host side of a serial link to a single-channel 16-bit DAC whose registers live in a 5-bit address space. Logic elsewhere on the chip issues register commands on a valid/ready port. Each command is a write, a read or a read-modify-write. The engine turns each command into one to three 32-bit serial frames, then reports completion with a one-cycle response strobe, the resulting 16-bit value and an error flag.

The DAC does not return read data in the frame that names the register. A read is therefore done in two frames. The first frame writes the readback-select register (address 0x13) with the target address. Chip select then goes high. The second frame is a no-operation frame, and the wanted value is shifted in during it. A read-modify-write reuses this two-frame read. It then clears the bits given by the mask from the value read, ORs in the supplied value, and writes the result back to the same address in a third frame.

The command port has one back-pressure rule. `cmd_ready` is high only while the engine is idle. It drops on the cycle after a command is accepted and stays low until the response strobe has been given. A caller may hold `cmd_valid` high with stable fields for as long as it likes, and exactly one command is taken per handshake. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and `rsp_data` and `rsp_err` are qualified by it.

Top module: `dac_spi_regio`

## Requirements
- R1: Every frame is 32 bits, sent MSB first. Bits [31:29] are 3'b100, bits [28:24] carry the register address, bits [23:8] carry the 16-bit data, and bits [7:0] are zero.
- R2: A write command (cmd_op = 0) sends exactly one frame to cmd_addr carrying cmd_data. The response returns cmd_data with rsp_err low.
- R3: A read command (cmd_op = 1) sends exactly two frames. The first goes to address 0x13 with the target address zero-extended in the data field, so the address sits at frame bits [12:8]. The second goes to address 0 with zero data. Chip select goes high between the two frames.
- R4: The read result is bits [23:8] of the word shifted in on MISO during the second frame. The bits received in [31:24] and [7:0] have no effect on the result.
- R5: A read-modify-write (cmd_op = 2) sends three frames: the two read frames, then a write to the same address carrying (read & ~cmd_mask) | cmd_data. The response returns that written value.
- R6: SCLK idles low while chip select is high. MOSI changes only while SCLK is low, and MISO is sampled on the rising edge. Each SCLK half period lasts SCLK_HALF system clocks, including the time from chip-select fall to the first rising edge.
- R7: Chip select stays high for at least CS_GAP system clocks between any two frames.
- R8: cmd_ready is low from the cycle after acceptance until after the response. Every accepted command produces exactly one single-cycle rsp_valid.
- R9: cmd_op = 3 is illegal. It produces a response with rsp_err high and no frame at all. Legal commands respond with rsp_err low.
- R10: After reset, chip select is high, SCLK is low, cmd_ready is high and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and accepting a command |
| cmd_op | input | 2 | 0 write, 1 read, 2 read-modify-write, 3 illegal |
| cmd_addr | input | 5 | Target register address |
| cmd_data | input | 16 | Write value, or value ORed in for read-modify-write |
| cmd_mask | input | 16 | Bits cleared from the read value before the OR |
| rsp_valid | output | 1 | Single-cycle completion strobe |
| rsp_data | output | 16 | Value written or read |
| rsp_err | output | 1 | Command was illegal |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the DAC |
| spi_miso | input | 1 | Serial data from the DAC |

## Verification
A sequencer stuck in the wrong phase shows up at the ports within one frame. The frame count per command, or the address of the select, no-operation or write-back frame, stops matching the command, or the response strobe never arrives. A wrong bit counter or capture window shifts the returned value by whole bits, and the first readback exposes it, because the test DAC model surrounds the data with non-zero filler bytes. Divider or gap errors appear on the first frame as wrong SCLK half-period lengths or a short chip-select high time.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int PAD_W   = 8;
  localparam int FRAME_W = 3 + ADDR_W + DATA_W + PAD_W;

  localparam logic [ADDR_W-1:0] RB_SEL_ADDR = 5'h13;
  localparam logic [ADDR_W-1:0] NOP_ADDR    = 5'h00;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_RMW   = 2'd2,
    OP_BAD   = 2'd3
  } op_e;

  function automatic logic [FRAME_W-1:0] frame_word(input logic [ADDR_W-1:0] a,
                                                    input logic [DATA_W-1:0] d);
    return {3'b100, a, d, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  generate
    if (HALF <= 1) begin : g_every
      assign tick = en;
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !en)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = en && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int FRAME_W = 32,
  parameter int RX_W    = 16,
  parameter int PAD_W   = 8,
  parameter int HALF    = 2,
  parameter int CS_GAP  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               ready,
  output logic               done,
  output logic [RX_W-1:0]    rx_data,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  localparam int BW = $clog2(FRAME_W + 1);
  localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [BW-1:0] ALL_BITS = BW'(FRAME_W);
  localparam logic [BW-1:0] CAP_END  = BW'(FRAME_W - PAD_W);
  localparam logic [GW-1:0] GAP_LAST = GW'(CS_GAP - 1);

  typedef enum logic [1:0] {F_IDLE, F_SHIFT, F_GAP} fst_e;

  fst_e               st;
  logic [FRAME_W-1:0] tx_q;
  logic [RX_W-1:0]    rx_q;
  logic [BW-1:0]      rises;
  logic [GW-1:0]      gap_q;
  logic               tick;

  spi_half_tick #(.HALF(HALF)) tick_i (
    .clk (clk),
    .rst (rst),
    .en  (st == F_SHIFT),
    .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= F_IDLE;
      tx_q  <= '0;
      rx_q  <= '0;
      rises <= '0;
      gap_q <= '0;
      sclk  <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        F_IDLE: begin
          if (start) begin
            tx_q  <= tx_word;
            cs_n  <= 1'b0;
            rises <= '0;
            st    <= F_SHIFT;
          end
        end
        F_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk  <= 1'b1;
              rises <= rises + 1'b1;
              // keep only the bits ahead of the trailing pad
              if (rises < CAP_END) rx_q <= {rx_q[RX_W-2:0], miso};
            end else begin
              sclk <= 1'b0;
              if (rises == ALL_BITS) begin
                cs_n  <= 1'b1;
                done  <= 1'b1;
                gap_q <= '0;
                st    <= F_GAP;
              end else begin
                tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
              end
            end
          end
        end
        F_GAP: begin
          if (gap_q == GAP_LAST) st <= F_IDLE;
          else                   gap_q <= gap_q + 1'b1;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assign ready   = (st == F_IDLE);
  assign rx_data = rx_q;
  assign mosi    = tx_q[FRAME_W-1];
endmodule

// File: rtl/dac_spi_txn_seq.sv
module dac_spi_txn_seq
  import dac_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_data,
  input  logic [DATA_W-1:0]  cmd_mask,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_err,
  input  logic               fr_ready,
  input  logic               fr_done,
  input  logic [DATA_W-1:0]  fr_rdata,
  output logic               fr_start,
  output logic [FRAME_W-1:0] fr_tx
);
  typedef enum logic [2:0] {
    Q_IDLE, Q_SEL_GO, Q_SEL_WT, Q_NOP_GO, Q_NOP_WT, Q_WR_GO, Q_WR_WT, Q_RESP
  } q_e;

  q_e                st;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] wval_q;
  logic [DATA_W-1:0] res_q;
  logic              err_q;

  always_comb begin
    cmd_ready = (st == Q_IDLE);
    rsp_valid = (st == Q_RESP);
    rsp_data  = res_q;
    rsp_err   = rsp_valid & err_q;
    fr_start  = 1'b0;
    fr_tx     = frame_word(NOP_ADDR, '0);
    case (st)
      Q_SEL_GO: begin
        fr_start = fr_ready;
        fr_tx    = frame_word(RB_SEL_ADDR, DATA_W'(addr_q));
      end
      Q_NOP_GO: fr_start = fr_ready;
      Q_WR_GO: begin
        fr_start = fr_ready;
        fr_tx    = frame_word(addr_q, wval_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= Q_IDLE;
      op_q   <= OP_WRITE;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
      wval_q <= '0;
      res_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        Q_IDLE: begin
          if (cmd_valid) begin
            op_q   <= op_e'(cmd_op);
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            mask_q <= cmd_mask;
            err_q  <= 1'b0;
            case (op_e'(cmd_op))
              OP_WRITE: begin
                wval_q <= cmd_data;
                st     <= Q_WR_GO;
              end
              OP_READ, OP_RMW: st <= Q_SEL_GO;
              default: begin
                err_q <= 1'b1;
                res_q <= '0;
                st    <= Q_RESP;
              end
            endcase
          end
        end
        Q_SEL_GO: if (fr_ready) st <= Q_SEL_WT;
        Q_SEL_WT: if (fr_done)  st <= Q_NOP_GO;
        Q_NOP_GO: if (fr_ready) st <= Q_NOP_WT;
        Q_NOP_WT: begin
          if (fr_done) begin
            if (op_q == OP_RMW) begin
              wval_q <= (fr_rdata & ~mask_q) | data_q;
              st     <= Q_WR_GO;
            end else begin
              res_q <= fr_rdata;
              st    <= Q_RESP;
            end
          end
        end
        Q_WR_GO: if (fr_ready) st <= Q_WR_WT;
        Q_WR_WT: begin
          if (fr_done) begin
            res_q <= wval_q;
            st    <= Q_RESP;
          end
        end
        Q_RESP:  st <= Q_IDLE;
        default: st <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_spi_regio.sv
module dac_spi_regio #(
  parameter int SCLK_HALF = 2,
  parameter int CS_GAP    = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [4:0]  cmd_addr,
  input  logic [15:0] cmd_data,
  input  logic [15:0] cmd_mask,
  output logic        rsp_valid,
  output logic [15:0] rsp_data,
  output logic        rsp_err,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  import dac_spi_pkg::*;

  logic                  fr_ready;
  logic                  fr_done;
  logic                  fr_start;
  logic [DATA_W-1:0]     fr_rdata;
  logic [FRAME_W-1:0]    fr_tx;

  dac_spi_txn_seq seq_i (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .cmd_mask (cmd_mask),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .rsp_err  (rsp_err),
    .fr_ready (fr_ready),
    .fr_done  (fr_done),
    .fr_rdata (fr_rdata),
    .fr_start (fr_start),
    .fr_tx    (fr_tx)
  );

  spi_frame_shifter #(
    .FRAME_W(FRAME_W),
    .RX_W   (DATA_W),
    .PAD_W  (PAD_W),
    .HALF   (SCLK_HALF),
    .CS_GAP (CS_GAP)
  ) shf_i (
    .clk    (clk),
    .rst    (rst),
    .start  (fr_start),
    .tx_word(fr_tx),
    .ready  (fr_ready),
    .done   (fr_done),
    .rx_data(fr_rdata),
    .sclk   (spi_sclk),
    .cs_n   (spi_cs_n),
    .mosi   (spi_mosi),
    .miso   (spi_miso)
  );
endmodule

// File: rtl/dac_spi_regio_chk.sv
module dac_spi_regio_chk #(
  parameter int CS_GAP = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic       spi_sclk,
  input logic       spi_cs_n,
  input logic       spi_mosi
);
  localparam int GW = $clog2(CS_GAP + 2) + 1;
  localparam logic [GW-1:0] GAP_MIN = GW'(CS_GAP);

  logic          inflight;
  logic          bad_inflight;
  logic [GW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight     <= 1'b0;
      bad_inflight <= 1'b0;
      hi_cnt       <= GAP_MIN;
    end else begin
      if (cmd_valid && cmd_ready) begin
        inflight     <= 1'b1;
        bad_inflight <= (cmd_op == 2'd3);
      end else if (rsp_valid) begin
        inflight     <= 1'b0;
        bad_inflight <= 1'b0;
      end
      if (spi_cs_n) begin
        if (hi_cnt < GAP_MIN) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
      end
    end
  end

  a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  a_r6_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  a_r7_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (hi_cnt >= GAP_MIN));

  a_r8_ready_low_in_flight: assert property (@(posedge clk) disable iff (rst)
    inflight |-> !cmd_ready);

  a_r8_rsp_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> inflight);

  a_r8_rsp_single_cycle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r9_no_frame_when_illegal: assert property (@(posedge clk) disable iff (rst)
    bad_inflight |-> spi_cs_n);

  a_r9_err_only_illegal: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && bad_inflight));
endmodule

bind dac_spi_regio dac_spi_regio_chk #(.CS_GAP(CS_GAP)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_op   (cmd_op),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err),
  .spi_sclk (spi_sclk),
  .spi_cs_n (spi_cs_n),
  .spi_mosi (spi_mosi)
);

// File: tb/dac_spi_regio_tb_top.sv
module dac_spi_regio_tb_top;
  localparam int HALF = 2;
  localparam int GAP  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [4:0]  cmd_addr = 5'd0;
  logic [15:0] cmd_data = 16'd0;
  logic [15:0] cmd_mask = 16'd0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        rsp_err;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #4 clk = ~clk;

  dac_spi_regio #(.SCLK_HALF(HALF), .CS_GAP(GAP)) dut_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // DAC model: samples MOSI on SCLK rise, drives MISO after falls
  logic [15:0] mem [32];
  logic [15:0] exp_mem [32];
  logic [4:0]  sel = 5'd0;
  logic [31:0] rx_sh = 32'd0;
  logic [31:0] tx_sh = 32'd0;
  int          nbits = 0;
  int          nfr = 0;
  int          badlen = 0;
  logic [31:0] frames [4];
  logic        miso_q = 1'b0;
  assign spi_miso = miso_q;

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i] = 16'd0;
      exp_mem[i] = 16'd0;
    end
    for (int i = 0; i < 4; i++) frames[i] = 32'd0;
  end

  always @(negedge spi_cs_n) begin
    tx_sh  = {8'hC3, mem[sel], 8'h7E};
    miso_q = tx_sh[31];
    nbits  = 0;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    rx_sh = {rx_sh[30:0], spi_mosi};
    nbits++;
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    tx_sh  = {tx_sh[30:0], 1'b0};
    miso_q = tx_sh[31];
  end

  always @(posedge spi_cs_n) if (!rst) begin
    if (nbits != 32) badlen++;
    if (nfr < 4) frames[nfr] = rx_sh;
    nfr++;
    if (rx_sh[28:24] == 5'h13)      sel = rx_sh[12:8];
    else if (rx_sh[28:24] != 5'h00) mem[rx_sh[28:24]] = rx_sh[23:8];
  end

  // pin timing monitors
  logic sclk_d = 1'b0, cs_d = 1'b1, mosi_d = 1'b0;
  int   since = 1, hi_run = 100;
  int   sclk_bad = 0, idle_bad = 0, mosi_bad = 0, gap_bad = 0;

  always @(negedge clk) if (!rst) begin
    if (spi_sclk !== sclk_d) begin
      if (!cs_d && since != HALF) sclk_bad++;
      since = 1;
    end else begin
      since++;
    end
    if (spi_cs_n && spi_sclk) idle_bad++;
    if (!spi_cs_n && spi_sclk && spi_mosi !== mosi_d) mosi_bad++;
    if (cs_d && !spi_cs_n) begin
      if (hi_run < GAP) gap_bad++;
      since = 1;
    end
    hi_run = spi_cs_n ? hi_run + 1 : 0;
    sclk_d = spi_sclk;
    cs_d   = spi_cs_n;
    mosi_d = spi_mosi;
  end

  int ready_bad = 0, pulse_bad = 0;

  task automatic do_cmd(input logic [1:0] op, input logic [4:0] a,
                        input logic [15:0] d, input logic [15:0] m,
                        output logic [15:0] rd, output logic er);
    nfr = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_mask = m;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) begin
      if (cmd_ready) ready_bad++;
      @(negedge clk);
    end
    rd = rsp_data;
    er = rsp_err;
    @(negedge clk);
    if (rsp_valid) pulse_bad++;
  endtask

  function automatic logic [31:0] fw(input logic [4:0] a, input logic [15:0] d);
    return {3'b100, a, d, 8'h00};
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", 200000);
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    logic        er;
    logic [15:0] nv;
    logic [4:0]  ra  [5];
    logic [15:0] rm  [5];
    logic [15:0] rvl [5];

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(spi_cs_n == 1'b1, "R10 cs_n", 32'(spi_cs_n), 32'd1);
    chk(spi_sclk == 1'b0, "R10 sclk", 32'(spi_sclk), 32'd0);
    chk(cmd_ready == 1'b1, "R10 cmd_ready", 32'(cmd_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R10 rsp_valid", 32'(rsp_valid), 32'd0);

    // R1 R2 write sweep over every storable address
    for (int a = 1; a < 32; a++) begin
      logic [15:0] d;
      if (a == 16'h13) continue;
      d = 16'(a * 16'h0931) ^ 16'hA55A;
      do_cmd(2'd0, 5'(a), d, 16'h0000, rd, er);
      exp_mem[a] = d;
      chk(nfr == 1, "R2 frame count", 32'(nfr), 32'd1);
      chk(frames[0] == fw(5'(a), d), "R1 write frame", frames[0], fw(5'(a), d));
      chk(rd == d, "R2 rsp_data", 32'(rd), 32'(d));
      chk(er == 1'b0, "R9 err on write", 32'(er), 32'd0);
      chk(mem[a] == d, "R2 DAC register", 32'(mem[a]), 32'(d));
    end

    // R3 R4 read sweep
    for (int a = 1; a < 32; a++) begin
      if (a == 16'h13) continue;
      do_cmd(2'd1, 5'(a), 16'hFFFF, 16'hFFFF, rd, er);
      chk(nfr == 2, "R3 frame count", 32'(nfr), 32'd2);
      chk(frames[0] == fw(5'h13, 16'(a)), "R3 select frame", frames[0], fw(5'h13, 16'(a)));
      chk(frames[1] == fw(5'h00, 16'h0000), "R3 nop frame", frames[1], fw(5'h00, 16'h0000));
      chk(rd == exp_mem[a], "R4 read value", 32'(rd), 32'(exp_mem[a]));
      chk(er == 1'b0, "R9 err on read", 32'(er), 32'd0);
    end

    // R5 read-modify-write patterns
    ra[0] = 5'd1;  rm[0] = 16'h00F0; rvl[0] = 16'h0050;
    ra[1] = 5'd5;  rm[1] = 16'hFFFF; rvl[1] = 16'h1234;
    ra[2] = 5'd7;  rm[2] = 16'h0000; rvl[2] = 16'h0000;
    ra[3] = 5'd9;  rm[3] = 16'h000F; rvl[3] = 16'h0300;
    ra[4] = 5'd31; rm[4] = 16'hE000; rvl[4] = 16'hA000;
    for (int k = 0; k < 5; k++) begin
      nv = (exp_mem[ra[k]] & ~rm[k]) | rvl[k];
      do_cmd(2'd2, ra[k], rvl[k], rm[k], rd, er);
      exp_mem[ra[k]] = nv;
      chk(nfr == 3, "R5 frame count", 32'(nfr), 32'd3);
      chk(frames[0] == fw(5'h13, 16'(ra[k])), "R5 select frame", frames[0], fw(5'h13, 16'(ra[k])));
      chk(frames[2] == fw(ra[k], nv), "R5 write-back frame", frames[2], fw(ra[k], nv));
      chk(rd == nv, "R5 rsp_data", 32'(rd), 32'(nv));
      do_cmd(2'd1, ra[k], 16'h0000, 16'h0000, rd, er);
      chk(rd == nv, "R5 readback after merge", 32'(rd), 32'(nv));
    end

    // R9 illegal op
    do_cmd(2'd3, 5'd4, 16'hBEEF, 16'h00FF, rd, er);
    chk(er == 1'b1, "R9 rsp_err", 32'(er), 32'd1);
    chk(nfr == 0, "R9 no frame", 32'(nfr), 32'd0);
    do_cmd(2'd1, 5'd4, 16'h0000, 16'h0000, rd, er);
    chk(rd == exp_mem[4], "R9 register untouched", 32'(rd), 32'(exp_mem[4]));

    repeat (10) @(negedge clk);
    chk(badlen == 0, "R1 frame length", 32'(badlen), 32'd0);
    chk(sclk_bad == 0, "R6 half period", 32'(sclk_bad), 32'd0);
    chk(idle_bad == 0, "R6 sclk idle low", 32'(idle_bad), 32'd0);
    chk(mosi_bad == 0, "R6 mosi steady while sclk high", 32'(mosi_bad), 32'd0);
    chk(gap_bad == 0, "R7 chip-select gap", 32'(gap_bad), 32'd0);
    chk(ready_bad == 0, "R8 ready low in flight", 32'(ready_bad), 32'd0);
    chk(pulse_bad == 0, "R8 single-cycle response", 32'(pulse_bad), 32'd0);
    finish_run();
  end
endmodule